// File: doc/BRIEF.md
# Two-Layer Alpha Overlay Blender

This block composites two image layers over a programmable background colour, one output pixel per input beat. Each input beat carries one 32-bit pixel word for every layer at the same screen position. The block tracks the raster position itself, in row-major order, inside a programmed frame width and height. For each position, layer 0 is blended over the background colour. Layer 1 is then blended over that result. A layer only takes part where it is enabled and its rectangle covers the position.

Each layer has its own control word. The control word picks where alpha comes from: the global value, the pixel's own alpha, or the product of the two. It also picks two weights on their own, one for the layer's colour and one for the colour beneath it. Each weight is one of alpha, one minus alpha, zero or one. Pixel words may use any of four byte orders.

Both streams use valid/ready. A beat moves when valid and ready are both high at a rising edge. `in_ready` is low exactly when the output holds a pixel that is not being taken. While it is low, the whole pipeline stands still and nothing is lost or reordered. Configuration is written through a plain write port and is meant to change only while the pipeline is empty.

Top module: `ovl_blender`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, both layers are disabled, the background colour is 0x000000 and the frame size is DEF_W x DEF_H, so every output pixel equals the background.
- R2: The output appears two rising edges after the input beat is accepted. `in_ready` is low only while `out_valid` is high and `out_ready` is low. While stalled, `out_rgb` holds. Pixels leave in arrival order, with none lost or duplicated.
- R3: Accepted beats take positions x = 0..W-1 along a row, then the next row y, and wrap to (0,0) after y = H-1. A write to the size register restarts the raster at (0,0).
- R4: A layer covers a position when its enable bit is 1 and x0 <= x <= x1 and y0 <= y <= y1 (inclusive corners). Where a layer does not cover a position, the colour beneath passes through unchanged.
- R5: The alpha mode in control bits [1:0] selects the alpha. Code 0 uses the global alpha in bits [22:15]. Code 1 uses the pixel alpha. Code 2 uses the normalised product of pixel and global alpha. Code 3 behaves as code 0.
- R6: The layer weight is in bits [3:2] and the beneath weight in bits [5:4]. Each is coded 0 = alpha, 1 = 255 - alpha, 2 = 0, 3 = 255, and the two are chosen independently.
- R7: Every product is (a*b + 127) / 255 in integer arithmetic. Each output component is the sum of the two weighted terms, saturated at 255.
- R8: The format code in bits [10:8] selects the byte order, listed from the most significant byte down. Code 5 is A,B,G,R. Code 6 is R,G,B,A. Code 7 is B,G,R,A. Code 4 and every other code is A,R,G,B.
- R9: Layer 0 is blended over the background colour and layer 1 over the result of layer 0. The output is {R[23:16], G[15:8], B[7:0]}.
- R10: Word addresses are: 0 size ({height[31:16], width[15:0]}); 1 background colour (RGB in bits [23:0]); 4 + 4*c control, 5 + 4*c top-left corner and 6 + 4*c bottom-right corner of layer c. Each corner is {y[31:16], x[15:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_pix | input | NCH*32 | Pixel word of layer c in bits [32c+31:32c] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgb | output | 24 | Blended pixel {R, G, B} |

## Verification
The hard case is an output stall landing in the same cycle as a new input beat at a position where both layer rectangles overlap. In that cycle the freeze of the whole pipeline meets a two-stage blend whose second weight sum saturates. The bench drives `out_ready` with a random pattern while it streams frames whose rectangles overlap, using full weights on both terms. A scoreboard holds the expected colour of every accepted beat. Each output handshake pops one entry and compares it, so a lost, repeated or misblended pixel shows up as a mismatch in value or order.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  // control word field positions
  localparam int F_MODE = 0;
  localparam int F_CO   = 2;
  localparam int F_CB   = 4;
  localparam int F_EN   = 6;
  localparam int F_FMT  = 8;
  localparam int F_GA   = 15;

  localparam logic [1:0] AM_PIXEL = 2'd1;
  localparam logic [1:0] AM_BOTH  = 2'd2;

  // (a*b + 127) / 255, rounded product of two 8-bit fractions
  function automatic logic [7:0] norm_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'(a) * 16'(b) + 16'd127;
    return 8'(p / 16'd255);
  endfunction

  function automatic logic [7:0] coef_pick(input logic [1:0] code, input logic [7:0] al);
    case (code)
      2'd0:    return al;
      2'd1:    return ~al;
      2'd2:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic argb_t unpack_px(input logic [31:0] w, input logic [2:0] fmt);
    argb_t p;
    case (fmt)
      3'd5:    p = '{a: w[31:24], b: w[23:16], g: w[15:8],  r: w[7:0]};
      3'd6:    p = '{r: w[31:24], g: w[23:16], b: w[15:8],  a: w[7:0]};
      3'd7:    p = '{b: w[31:24], g: w[23:16], r: w[15:8],  a: w[7:0]};
      default: p = '{a: w[31:24], r: w[23:16], g: w[15:8],  b: w[7:0]};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs #(
  parameter int CW     = 12,
  parameter int NCH    = 2,
  parameter int ADDR_W = 4,
  parameter int DEF_W  = 640,
  parameter int DEF_H  = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [CW-1:0]     width,
  output logic [CW-1:0]     height,
  output logic [23:0]       base,
  output logic [31:0]       ctrl [NCH],
  output logic [2*CW-1:0]   tl   [NCH],
  output logic [2*CW-1:0]   br   [NCH],
  output logic              restart
);

  assign restart = we && (addr == ADDR_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width  <= CW'(DEF_W);
      height <= CW'(DEF_H);
      base   <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(0)) begin
        width  <= wdata[CW-1:0];
        height <= wdata[16 +: CW];
      end
      if (addr == ADDR_W'(1)) base <= wdata[23:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int A0 = 4 * (c + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl[c] <= '0;
        tl[c]   <= '0;
        br[c]   <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(A0))     ctrl[c] <= wdata;
        if (addr == ADDR_W'(A0 + 1)) tl[c]   <= {wdata[16 +: CW], wdata[CW-1:0]};
        if (addr == ADDR_W'(A0 + 2)) br[c]   <= {wdata[16 +: CW], wdata[CW-1:0]};
      end
    end
  end

endmodule

// File: rtl/ovl_raster.sv
module ovl_raster #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y
);

  logic row_end, frame_end;
  assign row_end   = (x == width - CW'(1));
  assign frame_end = (y == height - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      x <= '0;
      y <= '0;
    end else if (step) begin
      if (row_end) begin
        x <= '0;
        y <= frame_end ? '0 : y + CW'(1);
      end else begin
        x <= x + CW'(1);
      end
    end
  end

  // R3: position frozen when no beat is accepted
  p_hold_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> ($stable(x) && $stable(y)));

  // R3: row wraps to column zero
  p_row_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && row_end) |=> (x == '0));

endmodule

// File: rtl/ovl_blend_stage.sv
module ovl_blend_stage
  import ovl_pkg::*;
#(
  parameter int CW  = 12,
  parameter int NCH = 2,
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_vld,
  input  logic [23:0]      in_color,
  input  logic [NCH*32-1:0] in_pix,
  input  logic [CW-1:0]    in_x,
  input  logic [CW-1:0]    in_y,
  input  logic [31:0]      ctrl,
  input  logic [2*CW-1:0]  tl,
  input  logic [2*CW-1:0]  br,
  output logic             out_vld,
  output logic [23:0]      out_color,
  output logic [NCH*32-1:0] out_pix,
  output logic [CW-1:0]    out_x,
  output logic [CW-1:0]    out_y
);

  argb_t       px;
  logic [7:0]  ga, alpha, k_own, k_low;
  logic        covered;
  logic [23:0] mixed;

  always_comb begin
    px = unpack_px(in_pix[IDX*32 +: 32], ctrl[F_FMT +: 3]);
    ga = ctrl[F_GA +: 8];
    case (ctrl[F_MODE +: 2])
      AM_PIXEL: alpha = px.a;
      AM_BOTH:  alpha = norm_mul(px.a, ga);
      default:  alpha = ga;
    endcase
    k_own   = coef_pick(ctrl[F_CO +: 2], alpha);
    k_low   = coef_pick(ctrl[F_CB +: 2], alpha);
    covered = ctrl[F_EN]
              && (in_x >= tl[CW-1:0])    && (in_x <= br[CW-1:0])
              && (in_y >= tl[CW +: CW])  && (in_y <= br[CW +: CW]);
    mixed = {sat_add(norm_mul(k_own, px.r), norm_mul(k_low, in_color[23:16])),
             sat_add(norm_mul(k_own, px.g), norm_mul(k_low, in_color[15:8])),
             sat_add(norm_mul(k_own, px.b), norm_mul(k_low, in_color[7:0]))};
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl[7], ctrl[14:11], ctrl[31:23]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_color <= '0;
      out_pix   <= '0;
      out_x     <= '0;
      out_y     <= '0;
    end else if (adv) begin
      out_vld   <= in_vld;
      out_color <= covered ? mixed : in_color;
      out_pix   <= in_pix;
      out_x     <= in_x;
      out_y     <= in_y;
    end
  end

  // R4: a disabled layer leaves the colour beneath untouched
  p_pass_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_vld && !ctrl[F_EN]) |=> (out_color == $past(in_color)));

  // R6: weights zero/one give the colour beneath
  p_zero_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_vld && covered && ctrl[F_CO +: 2] == 2'd2 && ctrl[F_CB +: 2] == 2'd3)
      |=> (out_color == $past(in_color)));

  // R6: weights zero/zero give black
  p_zero_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_vld && covered && ctrl[F_CO +: 2] == 2'd2 && ctrl[F_CB +: 2] == 2'd2)
      |=> (out_color == 24'h0));

endmodule

// File: rtl/ovl_blender.sv
module ovl_blender #(
  parameter int CW     = 12,
  parameter int NCH    = 2,
  parameter int ADDR_W = 4,
  parameter int DEF_W  = 640,
  parameter int DEF_H  = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*32-1:0] in_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [23:0]       out_rgb
);

  logic [CW-1:0]   width, height, rx, ry;
  logic [23:0]     base;
  logic [31:0]     ctrl_w [NCH];
  logic [2*CW-1:0] tl_w   [NCH];
  logic [2*CW-1:0] br_w   [NCH];
  logic            restart, adv;

  ovl_cfg_regs #(.CW(CW), .NCH(NCH), .ADDR_W(ADDR_W), .DEF_W(DEF_W), .DEF_H(DEF_H)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .width(width), .height(height), .base(base),
    .ctrl(ctrl_w), .tl(tl_w), .br(br_w), .restart(restart));

  // whole pipeline moves unless the output holds an untaken pixel
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  ovl_raster #(.CW(CW)) u_raster (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(in_valid && in_ready),
    .width(width), .height(height), .x(rx), .y(ry));

  logic              vld_s [NCH+1];
  logic [23:0]       col_s [NCH+1];
  logic [NCH*32-1:0] pix_s [NCH+1];
  logic [CW-1:0]     x_s   [NCH+1];
  logic [CW-1:0]     y_s   [NCH+1];

  assign vld_s[0] = in_valid;
  assign col_s[0] = base;
  assign pix_s[0] = in_pix;
  assign x_s[0]   = rx;
  assign y_s[0]   = ry;

  for (genvar c = 0; c < NCH; c++) begin : g_stage
    ovl_blend_stage #(.CW(CW), .NCH(NCH), .IDX(c)) u_stage (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(vld_s[c]), .in_color(col_s[c]), .in_pix(pix_s[c]),
      .in_x(x_s[c]), .in_y(y_s[c]),
      .ctrl(ctrl_w[c]), .tl(tl_w[c]), .br(br_w[c]),
      .out_vld(vld_s[c+1]), .out_color(col_s[c+1]), .out_pix(pix_s[c+1]),
      .out_x(x_s[c+1]), .out_y(y_s[c+1]));
  end

  assign out_valid = vld_s[NCH];
  assign out_rgb   = col_s[NCH];

  logic unused_tail;
  assign unused_tail = ^{pix_s[NCH], x_s[NCH], y_s[NCH]};

  // R2: a stalled output pixel holds its value
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

endmodule

// File: tb/tb_ovl_blender.sv
module tb_ovl_blender;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_pix;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_rgb;

  always #4 clk = ~clk;

  ovl_blender dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb));

  int    checks = 0, fails = 0;
  string req = "R1";
  bit    stall_en = 0;
  bit    done = 0;
  logic [23:0] expq[$];

  int          s_w = 640, s_h = 480, cx = 0, cy = 0;
  logic [23:0] s_base = '0;
  logic [31:0] s_ctrl [NCH] = '{default: '0};
  logic [31:0] s_tl   [NCH] = '{default: '0};
  logic [31:0] s_br   [NCH] = '{default: '0};

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int nm(input int a, input int b);
    return (a * b + 127) / 255;
  endfunction

  function automatic int wsel(input int code, input int al);
    case (code)
      0: return al;
      1: return 255 - al;
      2: return 0;
      default: return 255;
    endcase
  endfunction

  function automatic logic [23:0] layer(input int c, input logic [31:0] w, input logic [23:0] below,
                                        input int x, input int y);
    logic [31:0] k;
    int a, r, g, b, ga, al, ko, kl, o[3], lo[3];
    k = s_ctrl[c];
    if (!k[6] || x < int'(s_tl[c][11:0]) || x > int'(s_br[c][11:0]) ||
        y < int'(s_tl[c][27:16]) || y > int'(s_br[c][27:16])) return below;
    case (k[10:8])
      3'd5: begin a = w[31:24]; b = w[23:16]; g = w[15:8]; r = w[7:0]; end
      3'd6: begin r = w[31:24]; g = w[23:16]; b = w[15:8]; a = w[7:0]; end
      3'd7: begin b = w[31:24]; g = w[23:16]; r = w[15:8]; a = w[7:0]; end
      default: begin a = w[31:24]; r = w[23:16]; g = w[15:8]; b = w[7:0]; end
    endcase
    ga = k[22:15];
    case (k[1:0])
      2'd1: al = a;
      2'd2: al = nm(a, ga);
      default: al = ga;
    endcase
    ko = wsel(k[3:2], al);
    kl = wsel(k[5:4], al);
    o[0] = r; o[1] = g; o[2] = b;
    lo[0] = below[23:16]; lo[1] = below[15:8]; lo[2] = below[7:0];
    for (int i = 0; i < 3; i++) begin
      o[i] = nm(ko, o[i]) + nm(kl, lo[i]);
      if (o[i] > 255) o[i] = 255;
    end
    return {8'(o[0]), 8'(o[1]), 8'(o[2])};
  endfunction

  function automatic logic [23:0] model(input logic [63:0] p);
    logic [23:0] v;
    v = s_base;
    for (int c = 0; c < NCH; c++) v = layer(c, p[c*32 +: 32], v, cx, cy);
    return v;
  endfunction

  task automatic advance_pos();
    if (cx == s_w - 1) begin
      cx = 0;
      cy = (cy == s_h - 1) ? 0 : cy + 1;
    end else cx++;
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      0: begin s_w = d[11:0]; s_h = d[27:16]; cx = 0; cy = 0; end
      1: s_base = d[23:0];
      4: s_ctrl[0] = d;  5: s_tl[0] = d;  6: s_br[0] = d;
      8: s_ctrl[1] = d;  9: s_tl[1] = d; 10: s_br[1] = d;
      default: ;
    endcase
  endtask

  task automatic send(input logic [63:0] p);
    @(negedge clk);
    in_valid = 1; in_pix = p;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    expq.push_back(model(p));
    advance_pos();
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) send({$urandom, $urandom});
    idle();
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int mode, input int co, input int cb, input int en,
                                    input int fmt, input int ga);
    return 32'(mode) | (32'(co) << 2) | (32'(cb) << 4) | (32'(en) << 6) |
           (32'(fmt) << 8) | (32'(ga) << 15);
  endfunction

  always @(negedge clk) out_ready <= stall_en ? ($urandom % 3 != 0) : 1'b1;

  // scoreboard monitor: compares every output handshake
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s actual=%h expected=none (extra pixel)", req, out_rgb);
      end else check(req, {8'h0, out_rgb}, {8'h0, expq.pop_front()});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; in_valid = 0; in_pix = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check("R1", {31'h0, out_valid}, 32'h0);
    check("R1", {31'h0, in_ready}, 32'h1);
    req = "R1"; frame(4); drain();

    // R10/R9: size and background, layers off
    req = "R10/R9";
    wreg(0, {16'd3, 16'd4});
    wreg(1, 32'h00102030);
    frame(12); drain();

    // R4/R5/R6/R7: layer 0 global alpha over background, partial rectangle
    req = "R4/R5/R7";
    wreg(5, {16'd0, 16'd1});
    wreg(6, {16'd1, 16'd2});
    wreg(4, mk(0, 0, 1, 1, 4, 8'h80));
    frame(12); drain();

    // R8/R2: per-pixel alpha, layer 1 overlap with combined alpha, saturating weights, stalls
    req = "R8/R2/R7";
    stall_en = 1;
    wreg(5, 32'h0);
    wreg(6, {16'd2, 16'd3});
    wreg(4, mk(1, 0, 1, 1, 6, 0));
    wreg(9, {16'd1, 16'd1});
    wreg(10, {16'd1, 16'd2});
    wreg(8, mk(2, 3, 3, 1, 7, 8'h40));
    frame(24); drain();

    // R6/R8: zero weights on layer 0, odd format codes on both layers
    req = "R6/R8";
    wreg(4, mk(1, 2, 2, 1, 5, 0));
    wreg(8, mk(1, 1, 0, 1, 0, 0));
    frame(12); drain();
    wreg(4, mk(1, 0, 3, 1, 5, 0));
    frame(12); drain();

    // R3: size rewrite restarts the raster, single-pixel layer 1 marks the origin
    req = "R3";
    wreg(9, 32'h0);
    wreg(10, 32'h0);
    wreg(8, mk(0, 3, 2, 1, 4, 0));
    frame(5); drain();
    wreg(0, {16'd3, 16'd4});
    frame(14); drain();

    // R5: mode 3 acts as global alpha
    req = "R5";
    stall_en = 0;
    wreg(8, 32'h0);
    wreg(4, mk(3, 0, 1, 1, 4, 8'h33));
    frame(12); drain();

    // R2: latency of two edges with an empty pipeline
    req = "R2";
    @(negedge clk);
    in_valid = 1; in_pix = {$urandom, $urandom};
    #1;
    expq.push_back(model(in_pix));
    advance_pos();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    #1;
    check("R2", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    #1;
    check("R2", {31'h0, out_valid}, 32'h1);
    drain();

    check("R2", expq.size(), 32'h0);
    finish_run();
  end

endmodule